// File: doc/BRIEF.md
# Microprogram Forced-Entry Priority Controller

This block decides when the microprogram sequencer must drop its current flow and jump to a fixed service routine. It handles up to eight service requests, such as channel share requests, selector-channel requests and memory wrap. A request strobe is held in its own stacking latch until it is served. At each T1 timing pulse the controller looks at the pending requests. If the lock is clear and the manual gate is inactive, it fires one one-hot priority pulse for the highest-ranked eligible level. Together with that pulse it presents the fixed 7-bit entry address of that level and a single-cycle load strobe.

After a pulse, a two-stage lock holds off further entries. The any-priority latch arms on the T1 that fires the pulse, and the priority latch (the busy flag) follows at the next T3. The lock is released only by one of three timed events: a stop-loop indication at T1, a pending manual address load at P4, or a T3 after a microinstruction has written the control register. Three bits of the control register qualify the requests. The service routines set these bits themselves, which keeps a level from re-entering while its routine runs and lets memory wraps be ignored.

Top module: `fe_prio_ctrl`

## Requirements
- R1: Levels are ranked with PP1 (bit 0) highest and PP8 (bit 7) lowest. At a T1 edge with the lock clear and the manual gate inactive, exactly the highest-ranked eligible stacked level fires. Its bit of `pp_o` is high for the single cycle after that edge, and `pp_o` is zero otherwise.
- R2: Every accepted request strobe is held until its level fires, and each level fires once per accepted request. Simultaneous requests are therefore served one per lock cycle, in rank order. A level's stacking latch clears when its pulse fires. A new strobe on that same edge re-stacks it.
- R3: The cycle that carries the pulse also raises `entry_ld_o` with `entry_addr_o` set to the level's entry address. The default addresses for PP1 to PP8 are 0x04, 0x08, 0x0C, 0x10, 0x20, 0x28, 0x30 and 0x38. PP4 (memory wrap) always loads 0010000.
- R4: `allow_low_o` is high in the pulse cycle when the firing level is one of PP1 to PP4. `any_pp_o` is high in the pulse cycle for any level.
- R5: While control-register bit 2 is set, PP4 cannot fire. It stays pending, and lower-ranked levels may fire in its place. It fires once bit 2 clears.
- R6: While control-register bit 6 is set, a PP1 strobe is not stacked. While bit 5 is set, strobes for PP1, PP2 and PP3 are not stacked (PP2 and PP3 are the selector-channel levels). A strobe that is not stacked is lost and never fires later.
- R7: The T1 that fires a pulse sets the any-priority latch. The next T3 then raises `busy_o`. No pulse fires while either latch is set.
- R8: While `man_gate_i` is high, no pulse fires, and stacked requests stay pending.
- R9: A T1 with `stop_loop_i` high clears both lock latches.
- R10: A T1 with `man_load_i` high sets a manual latch. The next P4 then clears both lock latches, and the manual latch clears at that P4.
- R11: A cycle with `dst_creg_i` high sets a reset-control latch. The next T3 then clears both lock latches, and the reset-control latch clears at that T3.
- R12: A synchronous reset clears all latches and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Request strobes, bit 0 = PP1 |
| creg_i | input | 8 | Control register; bits 2, 5, 6 qualify requests |
| man_gate_i | input | 1 | Manual gate to address register active |
| man_load_i | input | 1 | Address register must be loaded manually |
| stop_loop_i | input | 1 | Stop-loop indication |
| dst_creg_i | input | 1 | Current microinstruction writes the control register |
| t1_i | input | 1 | T1 timing pulse |
| t3_i | input | 1 | T3 timing pulse |
| p4_i | input | 1 | P4 timing pulse |
| pp_o | output | 8 | One-hot priority pulse |
| entry_addr_o | output | 7 | Forced entry address |
| entry_ld_o | output | 1 | Load strobe for the entry address |
| allow_low_o | output | 1 | Pulse is one of PP1 to PP4 |
| any_pp_o | output | 1 | Any priority pulse |
| busy_o | output | 1 | Priority latch |

## Verification
The bench drives every non-empty combination of the eight requests at once and drains each combination level by level. A wrong rank or a lost or double-fired stack entry therefore shows up as a wrong `pp_o` or address in one of the drain steps. It checks that `busy_o` stays low until the T3 that follows the firing T1. A design that set the priority latch at T1 would show busy one phase too early, and one that forgot the any-priority latch would fire twice. It checks that masked strobes do not come back after their mask bit clears, whereas a suppressed PP4 does. A design that confused stacking masks with firing masks would get one of these two cases wrong. Each of the three release paths is exercised on its own strobe, so a release wired to the wrong timing pulse leaves `busy_o` stuck high.

// File: rtl/fe_pkg.sv
package fe_pkg;

  // lock-chain state: arming stage, priority stage, release qualifiers
  typedef struct packed {
    logic armed;   // any-priority latch
    logic held;    // priority latch
    logic manual;  // manual address-load latch
    logic creg_wr; // priority-reset-control latch
  } lock_t;

  localparam int unsigned DEF_LEVELS = 8;
  localparam int unsigned DEF_AW     = 7;

endpackage

// File: rtl/fe_stack.sv
module fe_stack #(
  parameter int unsigned NLVL     = 8,
  parameter int unsigned CRW      = 8,
  parameter int unsigned MPX_LVL  = 0,
  parameter logic [NLVL-1:0] SEL_MASK = 8'b0000_0110,
  parameter int unsigned MPXB_BIT = 6,
  parameter int unsigned SELB_BIT = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NLVL-1:0] req_i,
  input  logic [CRW-1:0]  creg_i,
  input  logic [NLVL-1:0] fire_i,
  output logic [NLVL-1:0] stk_o
);

  logic [NLVL-1:0] accept;

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    if (g == MPX_LVL) begin : g_mpx
      assign accept[g] = req_i[g] & ~creg_i[MPXB_BIT] & ~creg_i[SELB_BIT];
    end else if (SEL_MASK[g]) begin : g_sel
      assign accept[g] = req_i[g] & ~creg_i[SELB_BIT];
    end else begin : g_free
      assign accept[g] = req_i[g];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        stk_o[g] <= 1'b0;
      end else if (accept[g]) begin
        stk_o[g] <= 1'b1;
      end else if (fire_i[g]) begin
        stk_o[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fe_arbiter.sv
module fe_arbiter #(
  parameter int unsigned NLVL     = 8,
  parameter int unsigned AW       = 7,
  parameter int unsigned CRW      = 8,
  parameter int unsigned WRAP_LVL = 3,
  parameter int unsigned WRAP_BIT = 2,
  parameter logic [NLVL*AW-1:0] ENTRY_TBL = '0
) (
  input  logic [NLVL-1:0] stk_i,
  input  logic [CRW-1:0]  creg_i,
  input  logic            open_i,
  output logic [NLVL-1:0] fire_o,
  output logic [AW-1:0]   addr_o
);

  logic [NLVL-1:0] elig;

  always_comb begin
    elig = stk_i;
    elig[WRAP_LVL] = stk_i[WRAP_LVL] & ~creg_i[WRAP_BIT];
  end

  // strict rank: a level passes only when every higher one is idle
  always_comb begin
    logic taken;
    taken  = 1'b0;
    fire_o = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (open_i && elig[i] && !taken) begin
        fire_o[i] = 1'b1;
        taken     = 1'b1;
      end
    end
  end

  always_comb begin
    addr_o = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (fire_o[i]) begin
        addr_o = addr_o | ENTRY_TBL[i*AW +: AW];
      end
    end
  end

endmodule

// File: rtl/fe_lock.sv
module fe_lock
  import fe_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fire_any_i,
  input  logic man_load_i,
  input  logic stop_loop_i,
  input  logic dst_creg_i,
  input  logic t1_i,
  input  logic t3_i,
  input  logic p4_i,
  output logic armed_o,
  output logic held_o
);

  lock_t st_q, st_d;
  logic  release_w;

  assign release_w = (t1_i & stop_loop_i)
                   | (p4_i & st_q.manual)
                   | (t3_i & st_q.creg_wr);

  always_comb begin
    st_d = st_q;
    st_d.armed = fire_any_i | (st_q.armed & ~release_w);
    st_d.held  = ~release_w & (st_q.held | (t3_i & st_q.armed));

    if (t1_i && man_load_i) begin
      st_d.manual = 1'b1;
    end else if (p4_i) begin
      st_d.manual = 1'b0;
    end

    if (dst_creg_i) begin
      st_d.creg_wr = 1'b1;
    end else if (t3_i) begin
      st_d.creg_wr = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else begin
      st_q <= st_d;
    end
  end

  assign armed_o = st_q.armed;
  assign held_o  = st_q.held;

endmodule

// File: rtl/fe_prio_ctrl.sv
module fe_prio_ctrl #(
  parameter int unsigned NLVL     = fe_pkg::DEF_LEVELS,
  parameter int unsigned AW       = fe_pkg::DEF_AW,
  parameter int unsigned CRW      = 8,
  parameter int unsigned LOW_CNT  = 4,
  parameter int unsigned MPX_LVL  = 0,
  parameter int unsigned WRAP_LVL = 3,
  parameter logic [NLVL-1:0] SEL_MASK = 8'b0000_0110,
  parameter int unsigned WRAP_BIT = 2,
  parameter int unsigned SELB_BIT = 5,
  parameter int unsigned MPXB_BIT = 6,
  parameter logic [NLVL*AW-1:0] ENTRY_TBL =
    {7'h38, 7'h30, 7'h28, 7'h20, 7'h10, 7'h0C, 7'h08, 7'h04}
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NLVL-1:0] req_i,
  input  logic [CRW-1:0]  creg_i,
  input  logic            man_gate_i,
  input  logic            man_load_i,
  input  logic            stop_loop_i,
  input  logic            dst_creg_i,
  input  logic            t1_i,
  input  logic            t3_i,
  input  logic            p4_i,
  output logic [NLVL-1:0] pp_o,
  output logic [AW-1:0]   entry_addr_o,
  output logic            entry_ld_o,
  output logic            allow_low_o,
  output logic            any_pp_o,
  output logic            busy_o
);

  localparam int unsigned LOWW = (LOW_CNT > NLVL) ? NLVL : LOW_CNT;

  logic [NLVL-1:0] stk;
  logic [NLVL-1:0] fire;
  logic [AW-1:0]   fire_addr;
  logic            armed;
  logic            held;
  logic            open_w;
  logic            fire_any;

  assign open_w   = t1_i & ~armed & ~held & ~man_gate_i;
  assign fire_any = |fire;

  fe_stack #(
    .NLVL(NLVL), .CRW(CRW), .MPX_LVL(MPX_LVL), .SEL_MASK(SEL_MASK),
    .MPXB_BIT(MPXB_BIT), .SELB_BIT(SELB_BIT)
  ) u_stack (
    .clk(clk), .rst(rst), .req_i(req_i), .creg_i(creg_i),
    .fire_i(fire), .stk_o(stk)
  );

  fe_arbiter #(
    .NLVL(NLVL), .AW(AW), .CRW(CRW), .WRAP_LVL(WRAP_LVL),
    .WRAP_BIT(WRAP_BIT), .ENTRY_TBL(ENTRY_TBL)
  ) u_arb (
    .stk_i(stk), .creg_i(creg_i), .open_i(open_w),
    .fire_o(fire), .addr_o(fire_addr)
  );

  fe_lock u_lock (
    .clk(clk), .rst(rst), .fire_any_i(fire_any),
    .man_load_i(man_load_i), .stop_loop_i(stop_loop_i),
    .dst_creg_i(dst_creg_i), .t1_i(t1_i), .t3_i(t3_i), .p4_i(p4_i),
    .armed_o(armed), .held_o(held)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pp_o         <= '0;
      entry_addr_o <= '0;
      entry_ld_o   <= 1'b0;
      allow_low_o  <= 1'b0;
      any_pp_o     <= 1'b0;
    end else begin
      pp_o         <= fire;
      entry_addr_o <= fire_addr;
      entry_ld_o   <= fire_any;
      allow_low_o  <= |fire[LOWW-1:0];
      any_pp_o     <= fire_any;
    end
  end

  assign busy_o = held;

endmodule

// File: rtl/fe_prio_ctrl_chk.sv
module fe_prio_ctrl_chk #(
  parameter int unsigned NLVL     = 8,
  parameter int unsigned AW       = 7,
  parameter int unsigned WRAP_LVL = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [NLVL-1:0] pp_o,
  input logic [AW-1:0]   entry_addr_o,
  input logic            entry_ld_o,
  input logic            allow_low_o,
  input logic            any_pp_o,
  input logic            busy_o,
  input logic            man_gate_i,
  input logic            t3_i
);

  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pp_o)); // R1

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    entry_ld_o |=> !entry_ld_o); // R7

  AST_LOAD_WITH_PULSE: assert property (@(posedge clk) disable iff (rst)
    entry_ld_o |-> (pp_o != '0)); // R3

  AST_WRAP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    pp_o[WRAP_LVL] |-> (entry_addr_o == 7'b0010000)); // R3

  AST_LOW_IS_ANY: assert property (@(posedge clk) disable iff (rst)
    allow_low_o |-> any_pp_o); // R4

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> !entry_ld_o); // R7

  AST_BUSY_AT_T3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(t3_i)); // R7

  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    man_gate_i |=> !entry_ld_o); // R8

endmodule

bind fe_prio_ctrl fe_prio_ctrl_chk #(
  .NLVL(NLVL), .AW(AW), .WRAP_LVL(WRAP_LVL)
) u_chk (
  .clk(clk), .rst(rst), .pp_o(pp_o), .entry_addr_o(entry_addr_o),
  .entry_ld_o(entry_ld_o), .allow_low_o(allow_low_o), .any_pp_o(any_pp_o),
  .busy_o(busy_o), .man_gate_i(man_gate_i), .t3_i(t3_i)
);

// File: tb/fe_prio_ctrl_bench.sv
`timescale 1ns/1ps
module fe_prio_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] req_i;
  logic [7:0] creg_i;
  logic       man_gate_i, man_load_i, stop_loop_i, dst_creg_i;
  logic       t1_i, t3_i, p4_i;
  logic [7:0] pp_o;
  logic [6:0] entry_addr_o;
  logic       entry_ld_o, allow_low_o, any_pp_o, busy_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fe_prio_ctrl u_fe_prio_ctrl (
    .clk(clk), .rst(rst), .req_i(req_i), .creg_i(creg_i),
    .man_gate_i(man_gate_i), .man_load_i(man_load_i),
    .stop_loop_i(stop_loop_i), .dst_creg_i(dst_creg_i),
    .t1_i(t1_i), .t3_i(t3_i), .p4_i(p4_i),
    .pp_o(pp_o), .entry_addr_o(entry_addr_o), .entry_ld_o(entry_ld_o),
    .allow_low_o(allow_low_o), .any_pp_o(any_pp_o), .busy_o(busy_o)
  );

  function automatic logic [6:0] exp_addr(int lvl);
    case (lvl)
      0: return 7'h04;
      1: return 7'h08;
      2: return 7'h0C;
      3: return 7'b0010000;
      4: return 7'h20;
      5: return 7'h28;
      6: return 7'h30;
      default: return 7'h38;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_t1();
    t1_i = 1'b1; step(); t1_i = 1'b0;
  endtask

  task automatic do_t3();
    t3_i = 1'b1; step(); t3_i = 1'b0;
  endtask

  task automatic do_p4();
    p4_i = 1'b1; step(); p4_i = 1'b0;
  endtask

  task automatic raise(logic [7:0] r);
    req_i = r; step(); req_i = '0;
  endtask

  task automatic release_creg();
    dst_creg_i = 1'b1; step(); dst_creg_i = 1'b0;
    do_t3();
  endtask

  // fire expected level and check the whole pulse cycle
  task automatic expect_fire(string tag, int lvl);
    do_t1();
    check({tag, " pp"}, pp_o, 32'(8'b1 << lvl));
    check({tag, " ld"}, entry_ld_o, 1);
    check({tag, " addr"}, entry_addr_o, exp_addr(lvl));
    check({tag, " allow_low"}, allow_low_o, (lvl < 4) ? 1 : 0);
    check({tag, " any"}, any_pp_o, 1);
  endtask

  task automatic expect_none(string tag);
    do_t1();
    check({tag, " no pulse"}, {entry_ld_o, pp_o}, 0);
  endtask

  task automatic lock_cycle(string tag, int lvl);
    expect_fire(tag, lvl);
    check("R7 busy low after T1", busy_o, 0);
    do_t3();
    check("R7 busy after T3", busy_o, 1);
    check("R1 single-cycle pulse", pp_o, 0);
    release_creg();
    check("R11 release at T3", busy_o, 0);
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc_cnt);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_i = '0; creg_i = '0;
    man_gate_i = 0; man_load_i = 0; stop_loop_i = 0; dst_creg_i = 0;
    t1_i = 0; t3_i = 0; p4_i = 0;
    step(); step();
    rst = 1'b0;
    check("R12 reset outputs",
          {pp_o, entry_addr_o, entry_ld_o, allow_low_o, any_pp_o, busy_o}, 0);
    expect_none("R12 empty after reset");

    // R1 R2 R3 R4: every request combination drained in rank order
    for (int p = 1; p < 256; p++) begin
      logic [7:0] pend;
      pend = 8'(p);
      raise(pend);
      while (pend != 0) begin
        int lo;
        lo = 0;
        for (int b = 7; b >= 0; b--) if (pend[b]) lo = b;
        lock_cycle("R1 R2 R3 R4 sweep", lo);
        pend[lo] = 1'b0;
      end
      expect_none("R2 drained");
    end

    // R5: PP4 suppressed, lower level fires, then PP4 after bit clears
    creg_i = 8'h04;
    raise(8'b0010_1000);
    lock_cycle("R5 wrap suppressed", 5);
    expect_none("R5 wrap held");
    creg_i = 8'h00;
    lock_cycle("R5 wrap released", 3);

    // R6: bit 6 drops PP1 only; bit 5 drops PP1..PP3
    creg_i = 8'h40;
    raise(8'b0000_0011);
    creg_i = 8'h00;
    lock_cycle("R6 bit6 keeps PP2", 1);
    expect_none("R6 PP1 lost");
    creg_i = 8'h20;
    raise(8'b0000_1111);
    creg_i = 8'h00;
    lock_cycle("R6 bit5 keeps PP4", 3);
    expect_none("R6 selector and share lost");

    // R8: gate holds requests pending
    raise(8'b1000_0000);
    man_gate_i = 1'b1;
    expect_none("R8 gated");
    man_gate_i = 1'b0;
    lock_cycle("R8 after gate", 7);

    // R7: armed latch blocks second T1 before T3
    raise(8'b0001_0001);
    expect_fire("R7 first", 0);
    expect_none("R7 armed blocks");
    do_t3();
    check("R7 busy set", busy_o, 1);
    expect_none("R7 busy blocks");

    // R9: stop-loop at T1 releases
    stop_loop_i = 1'b1; do_t1(); stop_loop_i = 1'b0;
    check("R9 stop-loop release", busy_o, 0);
    check("R9 no pulse on release T1", entry_ld_o, 0);
    expect_fire("R9 next entry", 4);
    do_t3();
    check("R10 busy before manual", busy_o, 1);

    // R10: manual latch at T1, release at P4
    man_load_i = 1'b1; do_t1(); man_load_i = 1'b0;
    check("R10 still busy", busy_o, 1);
    do_p4();
    check("R10 manual release", busy_o, 0);
    raise(8'b0100_0000);
    expect_fire("R10 unlocked", 6);
    do_t3();
    do_p4();
    check("R10 manual latch cleared", busy_o, 1);
    release_creg();
    check("R11 final release", busy_o, 0);

    // R12: reset clears stacked request and lock
    raise(8'b0000_0100);
    expect_fire("R12 pre", 2);
    do_t3();
    raise(8'b0000_0010);
    rst = 1'b1; step(); rst = 1'b0;
    check("R12 busy cleared", busy_o, 0);
    expect_none("R12 stack cleared");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule